// File: doc/BRIEF.md
# Fall-Through FIFO with Ready Handshakes

This block is a single-clock first-in/first-out buffer, 64 words of 4 bits by default. It has a strobe-and-flag handshake on each side. A producer pulses `shift_in` while `in_ready` is high, and the word on `wr_data` is stored. A consumer sees `out_ready` high once a word sits at `rd_data` and pulses `shift_out` to take it. A word written into an empty buffer moves to the output by itself, with no read request.

Storage is a RAM array addressed by separate write and read pointers, and the output shows the word under the read pointer directly. An active-low master reset empties the buffer. An output-enable input turns the data output to high impedance and leaves the flags unaffected.

The flags are designed so that instances connect without glue logic. For more depth, the sender's `rd_data` feeds the receiver's `wr_data`, the receiver's `in_ready` drives the sender's `shift_out`, and the sender's `out_ready` drives the receiver's `shift_in`. For more width, the flags of instances placed side by side are ANDed.

Top module: `ft_fifo`

## Requirements
- R1: While `mrst_n` is low, and on the first cycle after it rises, `in_ready` is 1 and `out_ready` is 0, whatever the inputs did before reset.
- R2: A word accepted into an empty buffer gives `out_ready` = 1 and that word on `rd_data` on the next cycle, without any `shift_out`.
- R3: Words leave in the order they were accepted. A `shift_out` while `out_ready` is 1 consumes the word shown, and the next stored word appears on the following cycle.
- R4: `in_ready` is 0 exactly when DEPTH words are held, and 1 otherwise. A word is accepted on a rising edge only when `shift_in` and `in_ready` are both 1.
- R5: A `shift_in` while `in_ready` is 0 is ignored, even when `shift_out` is asserted in the same cycle. Draining afterwards returns exactly the words held before, in order.
- R6: A `shift_out` while `out_ready` is 0 is ignored. The flags stay at empty, and a later write still falls through correctly.
- R7: A `shift_in` and a `shift_out` that are both taken in the same cycle leave the occupancy unchanged. The fill that follows reaches full after exactly DEPTH minus the held count further writes.
- R8: While `out_en` is 0, `rd_data` is high impedance and the flags follow R2 to R4 unchanged. When `out_en` returns to 1, the head word is shown again.
- R9: Two instances chained for depth, with no added logic, accept 2×DEPTH words before the first instance's `in_ready` drops, and return them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, asynchronous; empties the buffer |
| shift_in | input | 1 | Write strobe; taken when `in_ready` is 1 |
| wr_data | input | WIDTH | Word to store |
| in_ready | output | 1 | 1 when a word can be accepted, 0 when full |
| shift_out | input | 1 | Consume strobe; taken when `out_ready` is 1 |
| out_ready | output | 1 | 1 when `rd_data` holds a valid word, 0 when empty |
| out_en | input | 1 | 1 drives `rd_data`, 0 puts it in high impedance |
| rd_data | output | WIDTH | Head word of the buffer |

## Verification
The properties assume that `mrst_n` goes low at least once before traffic starts. They also assume that the strobes and `wr_data` change only away from the rising edge. The stimulus sets every input just after a falling edge and sets `mrst_n` in the same way.

The high-impedance property accepts either an unknown or an all-zero output, so it also holds under a two-state model of the tristate driver. For this reason every high-impedance check is made with a nonzero word at the head. The chained pair is driven only through the strobes and flags of its outer ends, with its output enables tied high.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

   // Width of an index into a store of n entries (at least one bit).
   function automatic int unsigned ptr_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Width of a counter that has to reach n itself.
   function automatic int unsigned level_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   // Operation taken in one cycle: bit 0 = push, bit 1 = pop.
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10,
      OP_BOTH = 2'b11
   } ftf_op_e;

endpackage

// File: rtl/ftf_ram.sv
module ftf_ram #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 64,
   localparam int AW = ftf_pkg::ptr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // The read is combinational, so the head word is shown without a request.
   assign rdata = mem[raddr];

endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl #(
   parameter int DEPTH = 64,
   localparam int AW = ftf_pkg::ptr_bits(DEPTH),
   localparam int LW = ftf_pkg::level_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_in,
   input  logic          shift_out,
   output logic          wr_en,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [LW-1:0] level,
   output logic          in_ready,
   output logic          out_ready
);
   import ftf_pkg::*;

   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
   localparam bit            POW2     = (DEPTH == (1 << AW));

   logic          push;
   logic          pop;
   ftf_op_e       op;
   logic [AW-1:0] wr_nxt;
   logic [AW-1:0] rd_nxt;

   assign in_ready  = (level != FULL_LVL);
   assign out_ready = (level != '0);
   assign push      = shift_in & in_ready;
   assign pop       = shift_out & out_ready;
   assign op        = ftf_op_e'({pop, push});
   assign wr_en     = push;

   // A power-of-two depth wraps for free; any other depth compares with the last index.
   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_nxt;
         end
         if (pop) begin
            rd_ptr <= rd_nxt;
         end
         case (op)
            OP_PUSH: level <= level + 1'b1;
            OP_POP:  level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/ftf_obuf.sv
module ftf_obuf #(
   parameter int WIDTH = 4
) (
   input  logic             en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign dout[b] = en ? din[b] : 1'bz;
   end

endmodule

// File: rtl/ft_fifo.sv
module ft_fifo #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 64,
   localparam int AW = ftf_pkg::ptr_bits(DEPTH),
   localparam int LW = ftf_pkg::level_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             shift_in,
   input  logic [WIDTH-1:0] wr_data,
   output logic             in_ready,
   input  logic             shift_out,
   output logic             out_ready,
   input  logic             out_en,
   output logic [WIDTH-1:0] rd_data
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ft_fifo: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("ft_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic             wr_en;
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;
   logic [LW-1:0]    level;
   logic [WIDTH-1:0] head;

   ftf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
      .clk       (clk),
      .rst_n     (mrst_n),
      .shift_in  (shift_in),
      .shift_out (shift_out),
      .wr_en     (wr_en),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .level     (level),
      .in_ready  (in_ready),
      .out_ready (out_ready)
   );

   ftf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (head)
   );

   ftf_obuf #(.WIDTH(WIDTH)) i_obuf (
      .en   (out_en),
      .din  (head),
      .dout (rd_data)
   );

endmodule

// File: rtl/ftf_chk.sv
module ftf_chk #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 64,
   localparam int LW = ftf_pkg::level_bits(DEPTH)
) (
   input logic             clk,
   input logic             mrst_n,
   input logic             shift_in,
   input logic [WIDTH-1:0] wr_data,
   input logic             in_ready,
   input logic             shift_out,
   input logic             out_ready,
   input logic             out_en,
   input logic [WIDTH-1:0] rd_data,
   input logic [LW-1:0]    level
);

   // R1
   reset_flags_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(mrst_n) |-> (in_ready && !out_ready));

   // R2
   fall_through_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (!out_ready && shift_in && in_ready) |=>
         (out_ready && (!out_en || rd_data == $past(wr_data))));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (!in_ready && !(shift_out && out_ready)) |=> !in_ready);

   // R5
   full_ignore_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (shift_in && !in_ready && !shift_out) |=> $stable(level));

   // R6
   empty_ignore_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (shift_out && !out_ready && !shift_in) |=> (!out_ready && $stable(level)));

   // R7
   both_keep_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (shift_in && in_ready && shift_out && out_ready) |=> $stable(level));

   // R8
   hiz_out_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      !out_en |-> ($isunknown(rd_data) || rd_data == '0));

endmodule

bind ft_fifo ftf_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ftf_chk (
   .clk       (clk),
   .mrst_n    (mrst_n),
   .shift_in  (shift_in),
   .wr_data   (wr_data),
   .in_ready  (in_ready),
   .shift_out (shift_out),
   .out_ready (out_ready),
   .out_en    (out_en),
   .rd_data   (rd_data),
   .level     (level)
);

// File: tb/test_ft_fifo.sv
module test_ft_fifo;
   localparam int PERIOD = 10;
   localparam int WIDTH  = 4;
   localparam int DEPTH  = 64;

   logic clk = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   logic             rst_n;
   logic             si, so, oe;
   logic [WIDTH-1:0] d;
   wire  [WIDTH-1:0] q;
   logic             ir, orr;

   ft_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_ft_fifo (
      .clk(clk), .mrst_n(rst_n), .shift_in(si), .wr_data(d), .in_ready(ir),
      .shift_out(so), .out_ready(orr), .out_en(oe), .rd_data(q)
   );

   // Two instances chained for depth.
   logic             c_si, c_so;
   logic [WIDTH-1:0] c_d;
   wire  [WIDTH-1:0] c_mid, c_q;
   logic             c0_ir, c0_or, c1_ir, c1_or;

   ft_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_casc0 (
      .clk(clk), .mrst_n(rst_n), .shift_in(c_si), .wr_data(c_d), .in_ready(c0_ir),
      .shift_out(c1_ir), .out_ready(c0_or), .out_en(1'b1), .rd_data(c_mid)
   );
   ft_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_casc1 (
      .clk(clk), .mrst_n(rst_n), .shift_in(c0_or), .wr_data(c_mid), .in_ready(c1_ir),
      .shift_out(c_so), .out_ready(c1_or), .out_en(1'b1), .rd_data(c_q)
   );

   int               n_chk = 0;
   int               n_fail = 0;
   logic [WIDTH-1:0] exp_q[$];
   bit               mon_en = 1'b0;
   string            tag = "R3";
   string            tag_ir = "R4";
   string            tag_or = "R2";

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Driver: sets the inputs after a falling edge and pushes the accepted word into the model.
   task automatic step(input bit s_in, input bit s_out, input logic [WIDTH-1:0] w);
      bit acc;
      @(negedge clk);
      si = s_in;
      so = s_out;
      d  = w;
      acc = s_in && (exp_q.size() < DEPTH);
      #(PERIOD*3/8);
      if (acc) exp_q.push_back(w);
   endtask

   task automatic drain();
      for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, '0);
      step(1'b0, 1'b0, '0);
   endtask

   // Monitor: checks the flags each cycle and pops the expected word on each consume.
   always begin
      @(negedge clk);
      #(PERIOD/4);
      if (mon_en) begin
         chk(tag_ir, "in_ready", 32'(ir), 32'(exp_q.size() < DEPTH));
         chk(tag_or, "out_ready", 32'(orr), 32'(exp_q.size() > 0));
         if (so && exp_q.size() > 0) begin
            if (oe) chk(tag, "rd_data", 32'(q), 32'(exp_q[0]));
            void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      #(PERIOD*150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      report();
   end

   initial begin
      logic [WIDTH-1:0] cq[$];
      logic [15:0]      lf;
      int               acc_n;
      rst_n = 1'b0; si = 1'b0; so = 1'b0; oe = 1'b1; d = '0;
      c_si = 1'b0; c_so = 1'b0; c_d = '0;
      @(negedge clk);
      si = 1'b1; so = 1'b1;
      @(negedge clk);
      #(PERIOD/4);
      chk("R1", "in_ready in reset", 32'(ir), 32'd1);
      chk("R1", "out_ready in reset", 32'(orr), 32'd0);
      @(negedge clk);
      si = 1'b0; so = 1'b0;
      rst_n = 1'b1;
      #(PERIOD/4);
      chk("R1", "in_ready after reset", 32'(ir), 32'd1);
      chk("R1", "out_ready after reset", 32'(orr), 32'd0);
      mon_en = 1'b1;

      // R2: fall-through into an empty buffer
      tag = "R2";
      step(1'b1, 1'b0, 4'h5);
      step(1'b0, 1'b0, '0);
      step(1'b0, 1'b1, '0);
      step(1'b0, 1'b0, '0);

      // R6: consume on empty, then a write that still falls through
      tag = "R6"; tag_or = "R6";
      repeat (3) step(1'b0, 1'b1, '0);
      step(1'b1, 1'b0, 4'h3);
      step(1'b0, 1'b1, '0);
      step(1'b0, 1'b0, '0);
      tag_or = "R2";

      // R4: fill to full; R5: writes while full are ignored
      tag = "R5";
      for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 4'(i * 5 + 2));
      repeat (4) step(1'b1, 1'b0, 4'hF);
      step(1'b1, 1'b1, 4'hE);
      step(1'b0, 1'b0, '0);
      drain();

      // R7: simultaneous push and pop keep the occupancy
      tag = "R7"; tag_ir = "R7";
      for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 4'(i + 1));
      for (int i = 0; i < 50; i++) step(1'b1, 1'b1, 4'(i * 3));
      for (int i = 0; i < DEPTH - 10; i++) step(1'b1, 1'b0, 4'(i * 7));
      step(1'b0, 1'b0, '0);
      drain();
      tag_ir = "R4";

      // R3: mixed traffic
      tag = "R3";
      lf = 16'hACE1;
      for (int i = 0; i < 2000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0] | lf[9], lf[3], lf[7:4]);
      end
      drain();

      // R8: output disabled while holding words
      tag = "R8"; tag_or = "R8"; tag_ir = "R8";
      step(1'b1, 1'b0, 4'hA);
      step(1'b1, 1'b0, 4'h6);
      oe = 1'b0;
      step(1'b0, 1'b0, '0);
      chk("R8", "rd_data high impedance", 32'($isunknown(q) || q == '0), 32'd1);
      step(1'b1, 1'b0, 4'hB);
      chk("R8", "rd_data high impedance", 32'($isunknown(q) || q == '0), 32'd1);
      oe = 1'b1;
      step(1'b0, 1'b0, '0);
      chk("R8", "head shown again", 32'(q), 32'hA);
      drain();
      mon_en = 1'b0;

      // R9: depth cascade of two instances
      acc_n = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         c_si = c0_ir;
         c_d  = 4'(i * 7 + 1);
         if (c0_ir) begin
            cq.push_back(c_d);
            acc_n++;
         end
      end
      @(negedge clk);
      c_si = 1'b0;
      repeat (3) @(negedge clk);
      #(PERIOD/4);
      chk("R9", "words accepted", 32'(acc_n), 32'(2 * DEPTH));
      chk("R9", "first in_ready when full", 32'(c0_ir), 32'd0);
      chk("R9", "last out_ready when full", 32'(c1_or), 32'd1);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         c_so = 1'b1;
         #(PERIOD/4);
         if (c1_or) begin
            if (cq.size() > 0) begin
               chk("R9", "cascade data", 32'(c_q), 32'(cq[0]));
               void'(cq.pop_front());
            end else begin
               chk("R9", "extra word", 32'd1, 32'd0);
            end
         end
      end
      @(negedge clk);
      c_so = 1'b0;
      #(PERIOD/4);
      chk("R9", "words left over", 32'(cq.size()), 32'd0);
      chk("R9", "out_ready after drain", 32'(c1_or), 32'd0);
      report();
   end

endmodule